// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block takes a stereo audio stream carried on three wires: a bit clock, a channel select line and one serial data line that both channels share in turn. It works in the bit-clock domain. On every rising edge of the bit clock it samples the data line and the select line. It collects the bits of each half-frame into a 16-bit word and stores that word in the input register of the channel the select level names. The select line is high for the left channel and low for the right channel.

Framing is right-justified. The word for a half-frame is made of the last 16 bits that arrive before the select line changes level. When the select line goes from low to high, the stereo frame is over. At that edge both stored words are copied into the output holding registers on the same clock edge, so the two converter channels always change together. A one-cycle update strobe marks each transfer. Samples are two's-complement values, and the block passes them through without changing them.

Top module: `stereo_serial_rx`

## Requirements
- R1: The data line is sampled on each rising bit-clock edge, and the most significant bit of a word arrives first.
- R2: Bits sampled while the select line is high build the left word. Bits sampled while it is low build the right word. A high-to-low change of the select line stores the finished left word in the left input register.
- R3: If a half-frame holds more than 16 bits, only the last 16 are kept.
- R4: If a half-frame holds fewer than 16 bits (at least 1), the received bits fill the low end of the word and the upper bits are zero.
- R5: On the rising edge where the select line is first seen high after being low, both outputs load together: the left output takes the left input register and the right output takes the right word just finished. The update strobe is high for exactly the one cycle after that edge, and the registered select level is high while the strobe is high.
- R6: The outputs hold their values in every cycle without a strobe. A high-to-low change of the select line does not change the outputs.
- R7: While reset (active low) is asserted, every register is cleared: both outputs are zero, the strobe is low and the registered select level is low. As a result, the first high level seen after reset counts as the end of a frame.
- R8: Words are two's-complement values and reach the outputs bit for bit. This includes 16'h8000, 16'h7FFF and 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous |
| ws_in | input | 1 | Channel select: high for left, low for right |
| sd_in | input | 1 | Serial data, MSB first |
| left_out | output | 16 | Left sample held for the converter |
| right_out | output | 16 | Right sample held for the converter |
| load_pulse | output | 1 | One-cycle strobe after each simultaneous transfer |

## Verification
The bench sends half-frames that are longer than a word, shorter than a word, and one bit long.
- If the design kept the oldest bits of an overlong half-frame, the outputs would show the first bits sent.
- If it failed to clear the upper bits at a channel boundary, bits from the previous half-frame would leak into the top of a short word.

The bench also watches the outputs in every cycle between strobes.
- If the design loaded the left output at the high-to-low change of the select line, the mismatch would show there.
- If the strobe lasted longer than one cycle, that would show there as well.

Extreme two's-complement codes are used, so that any sign handling or swapped channel shows up as a wrong value on the output.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

  localparam int unsigned SSRX_WORD_W = 16;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } ch_sel_e;

endpackage

// File: rtl/ssrx_ws_track.sv
module ssrx_ws_track (
  input  logic bclk,
  input  logic rst_n,
  input  logic ws_in,
  output logic ws_q,
  output logic ws_rise,
  output logic ws_fall,
  output logic boundary
);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) ws_q <= 1'b0;
    else        ws_q <= ws_in;
  end

  assign ws_rise  = ws_in & ~ws_q;
  assign ws_fall  = ~ws_in & ws_q;
  assign boundary = ws_rise | ws_fall;

  // R5
  rise_not_repeated_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    ws_rise |=> !ws_rise);

endmodule

// File: rtl/ssrx_word_shift.sv
module ssrx_word_shift #(
  parameter int unsigned WORD_W = ssrx_pkg::SSRX_WORD_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sd_in,
  input  logic              boundary,
  output logic [WORD_W-1:0] shreg
);

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  function automatic logic [WORD_W-1:0] seed_bit(input logic b);
    logic [WORD_W-1:0] s;
    s    = '0;
    s[0] = b;
    return s;
  endfunction

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (boundary) shreg <= seed_bit(sd_in);
    else               shreg <= push_bit(shreg, sd_in);
  end

  // R4
  fresh_word_top_clear_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    boundary |=> (shreg[WORD_W-1:1] == '0));

endmodule

// File: rtl/ssrx_frame_latch.sv
module ssrx_frame_latch #(
  parameter int unsigned WORD_W = ssrx_pkg::SSRX_WORD_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              ws_rise,
  input  logic              ws_fall,
  input  logic [WORD_W-1:0] shreg,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              load_pulse
);
  import ssrx_pkg::*;

  logic [WORD_W-1:0] left_in;
  logic [WORD_W-1:0] right_in;
  ch_sel_e           done_ch;
  logic              commit;

  assign commit  = ws_rise | ws_fall;
  assign done_ch = ws_fall ? CH_LEFT : CH_RIGHT;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      left_in  <= '0;
      right_in <= '0;
    end else if (commit) begin
      if (done_ch == CH_LEFT) left_in  <= shreg;
      else                    right_in <= shreg;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      left_out   <= '0;
      right_out  <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= ws_rise;
      if (ws_rise) begin
        left_out  <= left_in;
        right_out <= shreg;
      end
    end
  end

  // R2
  left_commit_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    ws_fall |=> (left_in == $past(shreg)));

  // R5
  strobe_single_cycle_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  // R6
  outputs_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !load_pulse |-> ($stable(left_out) && $stable(right_out)));

  // R5
  right_in_follows_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    load_pulse |=> (right_in == $past(right_out)));

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int unsigned WORD_W = ssrx_pkg::SSRX_WORD_W
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              load_pulse
);

  logic              ws_q;
  logic              ws_rise;
  logic              ws_fall;
  logic              boundary;
  logic [WORD_W-1:0] shreg;

  ssrx_ws_track u_ws (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .ws_in    (ws_in),
    .ws_q     (ws_q),
    .ws_rise  (ws_rise),
    .ws_fall  (ws_fall),
    .boundary (boundary)
  );

  ssrx_word_shift #(.WORD_W(WORD_W)) u_shift (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .sd_in    (sd_in),
    .boundary (boundary),
    .shreg    (shreg)
  );

  ssrx_frame_latch #(.WORD_W(WORD_W)) u_latch (
    .bclk       (bclk),
    .rst_n      (rst_n),
    .ws_rise    (ws_rise),
    .ws_fall    (ws_fall),
    .shreg      (shreg),
    .left_out   (left_out),
    .right_out  (right_out),
    .load_pulse (load_pulse)
  );

  // R5
  strobe_after_high_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    load_pulse |-> ws_q);

  // R7
  reset_clear_chk: assert property (@(posedge bclk)
    !rst_n |-> (left_out == '0 && right_out == '0 && !load_pulse));

endmodule

// File: tb/test_stereo_serial_rx.sv
module test_stereo_serial_rx;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ws_in = 1'b0;
  logic        sd_in = 1'b0;
  logic [15:0] left_out;
  logic [15:0] right_out;
  logic        load_pulse;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          mon_on   = 1'b0;
  bit          done     = 1'b0;

  logic [31:0] exp_q[$];
  logic [15:0] pend_l = '0, pend_r = '0;
  logic [15:0] last_l = '0, last_r = '0;

  always #10 bclk = ~bclk;

  stereo_serial_rx i_stereo_serial_rx (
    .bclk(bclk), .rst_n(rst_n), .ws_in(ws_in), .sd_in(sd_in),
    .left_out(left_out), .right_out(right_out), .load_pulse(load_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] kept_word(input logic [31:0] s, input int n);
    if (n >= 16) return s[15:0];
    return s[15:0] & ((16'h1 << n) - 16'h1);
  endfunction

  task automatic drive_bit(input logic w, input logic b);
    @(negedge bclk);
    ws_in = w;
    sd_in = b;
  endtask

  // R1 R2: left half (select high) then right half (select low), MSB first
  task automatic send_frame(input logic [31:0] l, input int nl, input logic [31:0] r, input int nr);
    exp_q.push_back({pend_l, pend_r});
    for (int i = nl - 1; i >= 0; i--) drive_bit(1'b1, l[i]);
    for (int i = nr - 1; i >= 0; i--) drive_bit(1'b0, r[i]);
    pend_l = kept_word(l, nl);
    pend_r = kept_word(r, nr);
  endtask

  // scoreboard monitor
  always @(negedge bclk) begin
    if (mon_on && rst_n) begin
      if (load_pulse) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected strobe", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check("R5 R8 frame words", {left_out, right_out}, e);
          last_l = e[31:16];
          last_r = e[15:0];
        end
      end else begin
        check("R6 hold between strobes", {left_out, right_out}, {last_l, last_r});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge bclk);
    // R7 reset state
    check("R7 reset outputs", {left_out, right_out}, 32'h0);
    check("R7 reset strobe", {31'b0, load_pulse}, 32'h0);
    @(negedge bclk);
    rst_n  = 1'b1;
    mon_on = 1'b1;
    repeat (3) drive_bit(1'b0, 1'b0);
    // R1 R5 plain 16-bit words
    send_frame(32'h1234, 16, 32'hABCD, 16);
    // R8 extreme two's-complement codes
    send_frame(32'h8000, 16, 32'h7FFF, 16);
    // R3 overlong half-frames keep the last 16 bits
    send_frame(32'hF5A5A, 20, 32'h3C3C3, 18);
    // R4 short half-frames, zero-extended at the top
    send_frame(32'h5, 3, 32'h1, 1);
    // R4 short after long data: upper bits must not leak
    send_frame(32'hFFFF, 16, 32'h2A, 7);
    // R8 all ones and one
    send_frame(32'hFFFF, 16, 32'h0001, 16);
    // flush: final rise transfers the last frame
    exp_q.push_back({pend_l, pend_r});
    repeat (4) drive_bit(1'b1, 1'b0);
    repeat (3) @(negedge bclk);
    check("R5 all frames delivered", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule